// File: doc/BRIEF.md
# Load/Store Address Generation Decoder

This block takes one 32-bit instruction word from the miscellaneous load/store class: halfword transfers, signed-byte loads and dual-word loads. It works out everything the memory stage needs before an access starts: whether the word belongs to this class, the transfer direction and size, whether the loaded data is sign-extended, whether two words move, the effective memory address, the updated base value and whether that value is written back.

Offsets come from one of two sources. The first is an 8-bit immediate split across two nibbles of the word. The second is the index register value supplied at the inputs. The offset is added to or subtracted from the base. The address is formed before the access (pre-indexed) or after it (post-indexed).

Some variants have fixed rules. The unprivileged halfword and signed-byte forms always post-index and always write the base back. The literal dual-word form uses the program counter, aligned down to a 4-byte boundary, as its base. The decode is combinational and all outputs are captured in one output register stage.

Top module: `lsd_agu`

## Requirements
- R1: The word matches only when bits 27..25 are 000 and bits 7..4 are 1011 or 1101, subject to R3, R7 and R8. When the word does not match, match_o is 0 and every other output is 0, writeback enable included.
- R2: Bits 7..4 = 1011 gives a halfword transfer: size_o = 01, is_load_o = bit 20, sext_o = 0 and dual_o = 0. Bits 7..4 = 1101 with bit 20 set gives a signed-byte load: size_o = 00, is_load_o = 1 and sext_o = 1. Bits 7..4 = 1101 with bit 20 clear gives a dual-word load: size_o = 10, is_load_o = 1 and dual_o = 1.
- R3: When bit 22 is 1, the offset is the zero-extended 8-bit immediate {bits 11..8, bits 3..0}. When bit 22 is 0, the offset is index_val, and bits 11..8 must be 0000; otherwise the word does not match.
- R4: When bit 23 is 1, the offset is added to the base. When bit 23 is 0, it is subtracted. The arithmetic is modulo 2^AW.
- R5: Pre-indexed (bit 24 = 1): mem_addr_o = base ± offset, new_base_o holds the same value, and wb_en_o = bit 21.
- R6: Post-indexed (bit 24 = 0): mem_addr_o = the unmodified base, new_base_o = base ± offset, and wb_en_o = 1. This covers the unprivileged halfword and signed-byte forms (bit 24 = 0, bit 21 = 1).
- R7: A dual-word load with bit 24 = 0 and bit 21 = 1 does not match.
- R8: A dual-word load with bit 22 = 1 and bits 19..16 = 1111 is the literal form. Its base is pc_val with bits 1..0 cleared, and wb_en_o = 0. It matches only with bit 24 = 1 and bit 21 = 0. In every other form the base is base_val, even when bits 19..16 = 1111.
- R9: Outputs appear one clock after the inputs are sampled. While rst_n is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 32 | Instruction word |
| base_val | input | AW | Base register value |
| index_val | input | AW | Index register value |
| pc_val | input | AW | Program counter value |
| match_o | output | 1 | Word belongs to this class and is a legal form |
| is_load_o | output | 1 | 1 = load, 0 = store |
| size_o | output | 2 | Access size: 00 byte, 01 halfword, 10 word |
| sext_o | output | 1 | Loaded data is sign-extended |
| dual_o | output | 1 | Two consecutive words are transferred |
| wb_en_o | output | 1 | Write new_base_o back to the base register |
| mem_addr_o | output | AW | Effective memory address |
| new_base_o | output | AW | Updated base value |

## Verification
Random words are drawn with most of them forced into the class. The sub-type nibble is picked among 1011, 1101 and other values, the register form sometimes has bits 11..8 cleared, and the base field is sometimes 1111. This spread separates halfword from signed-byte from dual decoding, and immediate offsets from index-register offsets. It also separates add from subtract and pre-indexed from post-indexed addressing.

Directed words then cover the cases random stimulus rarely reaches:
- an unprivileged post-indexed load;
- a dual form with P = 0 and W = 1, which must be rejected;
- the literal form, both legal and illegal, against a misaligned program counter;
- a base field of 1111 outside the literal form, which must still use base_val;
- a carry wrap of the address;
- words outside the class.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } size_e;

  typedef struct packed {
    logic  match;
    logic  is_load;
    size_e size;
    logic  sext;
    logic  dual;
    logic  pre;
    logic  wb_req;
    logic  literal;
    logic  add;
  } cls_t;

endpackage

// File: rtl/lsd_class_decode.sv
module lsd_class_decode
  import lsd_pkg::*;
(
  input  logic [27:0] ins,
  output cls_t        cls
);

  localparam logic [3:0] TYPE_HALF = 4'b1011;
  localparam logic [3:0] TYPE_SBD  = 4'b1101;

  logic class_hit, reg_ok, is_half, is_sbd;
  logic p_bit, w_bit, l_bit, i_bit, rn_pc;
  logic unused_bits;
  cls_t raw;

  assign unused_bits = ^{ins[15:12], ins[3:0]};

  assign p_bit     = ins[24];
  assign w_bit     = ins[21];
  assign l_bit     = ins[20];
  assign i_bit     = ins[22];
  assign rn_pc     = (ins[19:16] == 4'hF);
  assign class_hit = (ins[27:25] == 3'b000);
  assign reg_ok    = i_bit || (ins[11:8] == 4'h0);
  assign is_half   = (ins[7:4] == TYPE_HALF);
  assign is_sbd    = (ins[7:4] == TYPE_SBD);

  always_comb begin
    raw         = '0;
    raw.pre     = p_bit;
    raw.wb_req  = p_bit ? w_bit : 1'b1;
    raw.add     = ins[23];
    if (class_hit && reg_ok) begin
      if (is_half) begin
        raw.match   = 1'b1;
        raw.is_load = l_bit;
        raw.size    = SZ_HALF;
      end else if (is_sbd && l_bit) begin
        raw.match   = 1'b1;
        raw.is_load = 1'b1;
        raw.size    = SZ_BYTE;
        raw.sext    = 1'b1;
      end else if (is_sbd) begin
        raw.is_load = 1'b1;
        raw.size    = SZ_WORD;
        raw.dual    = 1'b1;
        raw.literal = i_bit && rn_pc;
        if (raw.literal) raw.match = p_bit && !w_bit;
        else             raw.match = !(!p_bit && w_bit);
      end
    end
  end

  assign cls = raw.match ? raw : '0;

endmodule

// File: rtl/lsd_offset_sel.sv
module lsd_offset_sel #(
  parameter int AW = 32
) (
  input  logic          use_imm,
  input  logic [3:0]    imm_hi,
  input  logic [3:0]    imm_lo,
  input  logic [AW-1:0] index_val,
  output logic [AW-1:0] offset
);

  localparam int IMM_W = 8;

  logic [IMM_W-1:0] imm8;

  assign imm8   = {imm_hi, imm_lo};
  assign offset = use_imm ? {{(AW-IMM_W){1'b0}}, imm8} : index_val;

endmodule

// File: rtl/lsd_addr_calc.sv
module lsd_addr_calc
  import lsd_pkg::*;
#(
  parameter int AW = 32
) (
  input  cls_t          cls,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] pc_val,
  input  logic [AW-1:0] offset,
  output logic [AW-1:0] mem_addr,
  output logic [AW-1:0] new_base,
  output logic          wb_en
);

  localparam int ALIGN_W = 2;

  logic [AW-1:0] base_sel, sum;
  logic [ALIGN_W-1:0] unused_pc_low;

  assign unused_pc_low = pc_val[ALIGN_W-1:0];
  assign base_sel = cls.literal ? {pc_val[AW-1:ALIGN_W], {ALIGN_W{1'b0}}} : base_val;
  assign sum      = cls.add ? (base_sel + offset) : (base_sel - offset);

  always_comb begin
    if (cls.match) begin
      mem_addr = cls.pre ? sum : base_sel;
      new_base = sum;
      wb_en    = cls.wb_req && !cls.literal;
    end else begin
      mem_addr = '0;
      new_base = '0;
      wb_en    = 1'b0;
    end
  end

endmodule

// File: rtl/lsd_agu.sv
module lsd_agu
  import lsd_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   instr,
  input  logic [AW-1:0] base_val,
  input  logic [AW-1:0] index_val,
  input  logic [AW-1:0] pc_val,
  output logic          match_o,
  output logic          is_load_o,
  output logic [1:0]    size_o,
  output logic          sext_o,
  output logic          dual_o,
  output logic          wb_en_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [AW-1:0] new_base_o
);

  typedef struct packed {
    logic          match;
    logic          is_load;
    logic [1:0]    size;
    logic          sext;
    logic          dual;
    logic          wb_en;
    logic [AW-1:0] addr;
    logic [AW-1:0] nbase;
  } out_t;

  cls_t          cls;
  logic [AW-1:0] offset, addr_c, nbase_c;
  logic          wb_c;
  logic [3:0]    unused_cond;
  out_t          out_d, out_q;

  assign unused_cond = instr[31:28];

  lsd_class_decode u_dec (
    .ins (instr[27:0]),
    .cls (cls)
  );

  lsd_offset_sel #(.AW(AW)) u_off (
    .use_imm   (instr[22]),
    .imm_hi    (instr[11:8]),
    .imm_lo    (instr[3:0]),
    .index_val (index_val),
    .offset    (offset)
  );

  lsd_addr_calc #(.AW(AW)) u_calc (
    .cls      (cls),
    .base_val (base_val),
    .pc_val   (pc_val),
    .offset   (offset),
    .mem_addr (addr_c),
    .new_base (nbase_c),
    .wb_en    (wb_c)
  );

  always_comb begin
    out_d         = '0;
    out_d.match   = cls.match;
    out_d.is_load = cls.is_load;
    out_d.size    = cls.size;
    out_d.sext    = cls.sext;
    out_d.dual    = cls.dual;
    out_d.wb_en   = wb_c;
    out_d.addr    = addr_c;
    out_d.nbase   = nbase_c;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assign match_o    = out_q.match;
  assign is_load_o  = out_q.is_load;
  assign size_o     = out_q.size;
  assign sext_o     = out_q.sext;
  assign dual_o     = out_q.dual;
  assign wb_en_o    = out_q.wb_en;
  assign mem_addr_o = out_q.addr;
  assign new_base_o = out_q.nbase;

endmodule

// File: rtl/lsd_agu_chk.sv
module lsd_agu_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [31:0]   instr,
  input logic [AW-1:0] base_val,
  input logic          match_o,
  input logic          is_load_o,
  input logic [1:0]    size_o,
  input logic          sext_o,
  input logic          dual_o,
  input logic          wb_en_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [AW-1:0] new_base_o
);

  a_r1_nomatch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !match_o |-> (!wb_en_o && !dual_o && !sext_o && mem_addr_o == '0 && new_base_o == '0));

  a_r1_class_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(instr[27:25]) != 3'b000) |-> !match_o);

  a_r2_sext_byte: assert property (@(posedge clk) disable iff (!rst_n)
    sext_o |-> (is_load_o && size_o == 2'b00 && !dual_o));

  a_r2_dual_word: assert property (@(posedge clk) disable iff (!rst_n)
    dual_o |-> (is_load_o && size_o == 2'b10 && !sext_o));

  a_r6_post_base: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && match_o && !$past(instr[24])) |-> (mem_addr_o == $past(base_val) && wb_en_o));

  a_r7_dual_unpriv: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(instr[7:4]) == 4'b1101 && !$past(instr[20]) &&
     !$past(instr[24]) && $past(instr[21])) |-> !match_o);

  a_r8_literal_nowb: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && dual_o && $past(instr[22]) && $past(instr[19:16]) == 4'hF) |-> !wb_en_o);

endmodule

bind lsd_agu lsd_agu_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .instr      (instr),
  .base_val   (base_val),
  .match_o    (match_o),
  .is_load_o  (is_load_o),
  .size_o     (size_o),
  .sext_o     (sext_o),
  .dual_o     (dual_o),
  .wb_en_o    (wb_en_o),
  .mem_addr_o (mem_addr_o),
  .new_base_o (new_base_o)
);

// File: tb/lsd_agu_tb.sv
module lsd_agu_tb;

  localparam int AW = 32;

  typedef struct packed {
    logic          match;
    logic          ld;
    logic [1:0]    sz;
    logic          sx;
    logic          du;
    logic          wb;
    logic [AW-1:0] addr;
    logic [AW-1:0] nb;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [31:0]   instr = '0;
  logic [AW-1:0] base_val = '0, index_val = '0, pc_val = '0;
  logic          match_o, is_load_o, sext_o, dual_o, wb_en_o;
  logic [1:0]    size_o;
  logic [AW-1:0] mem_addr_o, new_base_o;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  lsd_agu #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .instr(instr), .base_val(base_val),
    .index_val(index_val), .pc_val(pc_val), .match_o(match_o),
    .is_load_o(is_load_o), .size_o(size_o), .sext_o(sext_o),
    .dual_o(dual_o), .wb_en_o(wb_en_o), .mem_addr_o(mem_addr_o),
    .new_base_o(new_base_o)
  );

  function automatic exp_t model(input logic [31:0] w, input logic [AW-1:0] b,
                                 input logic [AW-1:0] x, input logic [AW-1:0] p);
    exp_t e;
    logic [AW-1:0] off, bs, res;
    logic lit;
    e = '0;
    if (w[27:25] != 3'b000) return e;
    if (w[7:4] != 4'b1011 && w[7:4] != 4'b1101) return e;
    if (!w[22] && w[11:8] != 4'h0) return e;
    off = w[22] ? AW'({w[11:8], w[3:0]}) : x;
    lit = 1'b0;
    case ({w[7:4] == 4'b1101, w[20]})
      2'b00, 2'b01: begin e.ld = w[20]; e.sz = 2'b01; end
      2'b11: begin e.ld = 1'b1; e.sz = 2'b00; e.sx = 1'b1; end
      default: begin
        e.ld = 1'b1; e.sz = 2'b10; e.du = 1'b1;
        if (!w[24] && w[21]) return '0;
        lit = w[22] && (w[19:16] == 4'hF);
        if (lit && !(w[24] && !w[21])) return '0;
      end
    endcase
    e.match = 1'b1;
    bs  = lit ? (p & ~AW'(3)) : b;
    res = w[23] ? bs + off : bs - off;
    e.addr = w[24] ? res : bs;
    e.nb   = res;
    e.wb   = lit ? 1'b0 : (w[24] ? w[21] : 1'b1);
    return e;
  endfunction

  function automatic logic [31:0] mk(input logic p, input logic u, input logic i,
      input logic w, input logic l, input logic [3:0] rn, input logic [3:0] hi,
      input logic [3:0] t, input logic [3:0] lo);
    return {4'hE, 3'b000, p, u, i, w, l, rn, 4'h3, hi, t, lo};
  endfunction

  function automatic string tag_of(input exp_t e, input logic [31:0] w);
    if (!e.match) return "R1";
    if (e.du && w[22] && w[19:16] == 4'hF) return "R8";
    if (w[24]) return "R5";
    return "R6";
  endfunction

  task automatic compare(input string tag, input exp_t e);
    exp_t a;
    a = '{match_o, is_load_o, size_o, sext_o, dual_o, wb_en_o, mem_addr_o, new_base_o};
    n_run++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s instr=%h got m=%b l=%b s=%b x=%b d=%b wb=%b a=%h nb=%h exp m=%b l=%b s=%b x=%b d=%b wb=%b a=%h nb=%h",
        tag, instr, a.match, a.ld, a.sz, a.sx, a.du, a.wb, a.addr, a.nb,
        e.match, e.ld, e.sz, e.sx, e.du, e.wb, e.addr, e.nb);
    end
  endtask

  task automatic apply(input string tag, input logic [31:0] w, input logic [AW-1:0] b,
                       input logic [AW-1:0] x, input logic [AW-1:0] p);
    instr = w; base_val = b; index_val = x; pc_val = p;
    @(posedge clk);
    @(negedge clk);
    compare(tag, model(w, b, x, p));
  endtask

  task automatic check_val(input string tag, input logic [AW-1:0] got, input logic [AW-1:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'h5EED_1234));
    instr = mk(1, 1, 1, 1, 1, 4'h1, 4'h1, 4'b1011, 4'h1);
    base_val = 32'h1234;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset holds every output at zero
    compare("R9", '0);
    rst_n = 1'b1;

    // R2 R5: halfword store, pre-indexed, immediate add, writeback
    apply("R5", mk(1, 1, 1, 1, 0, 4'h1, 4'h3, 4'b1011, 4'h4), 32'h1000, 32'h0, 32'h0);
    check_val("R5", mem_addr_o, 32'h1034);
    // R5: pre-indexed without W gives no writeback
    apply("R5", mk(1, 0, 1, 0, 1, 4'h2, 4'h0, 4'b1011, 4'h8), 32'h2000, 32'h0, 32'h0);
    // R2 R4 R6: signed byte load, post-indexed, register subtract
    apply("R6", mk(0, 0, 0, 0, 1, 4'h3, 4'h0, 4'b1101, 4'h5), 32'h3000, 32'h40, 32'h0);
    check_val("R6", new_base_o, 32'h2FC0);
    // R6: unprivileged halfword load
    apply("R6", mk(0, 1, 1, 1, 1, 4'h4, 4'h0, 4'b1011, 4'h2), 32'h4000, 32'h0, 32'h0);
    // R3: register form with nonzero bits 11..8 rejected
    apply("R3", mk(1, 1, 0, 0, 0, 4'h5, 4'h2, 4'b1101, 4'h6), 32'h5000, 32'h8, 32'h0);
    // R2 R3: dual register form legal
    apply("R3", mk(1, 1, 0, 1, 0, 4'h5, 4'h0, 4'b1101, 4'h6), 32'h5000, 32'h8, 32'h0);
    // R7: dual with P=0 W=1 rejected
    apply("R7", mk(0, 1, 1, 1, 0, 4'h6, 4'h0, 4'b1101, 4'h4), 32'h6000, 32'h0, 32'h0);
    // R8: literal dual, misaligned pc, subtract
    apply("R8", mk(1, 0, 1, 0, 0, 4'hF, 4'h1, 4'b1101, 4'h0), 32'h9999, 32'h0, 32'h1003);
    check_val("R8", mem_addr_o, 32'h0FF0);
    // R8: literal with W=1 rejected
    apply("R8", mk(1, 0, 1, 1, 0, 4'hF, 4'h1, 4'b1101, 4'h0), 32'h9999, 32'h0, 32'h1003);
    // R8: base field 1111 on halfword uses base_val
    apply("R8", mk(1, 1, 1, 0, 1, 4'hF, 4'h0, 4'b1011, 4'h4), 32'h7000, 32'h0, 32'hABC0);
    check_val("R8", mem_addr_o, 32'h7004);
    // R4: wraparound
    apply("R4", mk(1, 1, 1, 0, 1, 4'h1, 4'h2, 4'b1011, 4'h0), 32'hFFFF_FFF0, 32'h0, 32'h0);
    check_val("R4", mem_addr_o, 32'h0000_0010);
    // R1: outside class and wrong sub-type
    apply("R1", mk(1, 1, 1, 1, 1, 4'h1, 4'h0, 4'b1011, 4'h0) | 32'h0200_0000, 32'h1, 32'h0, 32'h0);
    apply("R1", mk(1, 1, 1, 1, 1, 4'h1, 4'h0, 4'b1111, 4'h0), 32'h1, 32'h0, 32'h0);

    for (int k = 0; k < 600; k++) begin
      w = $urandom;
      if ($urandom % 8 != 0) w[27:25] = 3'b000;
      case ($urandom % 5)
        0, 1: w[7:4] = 4'b1011;
        2, 3: w[7:4] = 4'b1101;
        default: ;
      endcase
      if (!w[22] && ($urandom % 2 == 0)) w[11:8] = 4'h0;
      if ($urandom % 4 == 0) w[19:16] = 4'hF;
      apply(tag_of(model(w, 0, 0, 0), w), w, $urandom, $urandom, $urandom);
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule